// File: doc/BRIEF.md
# SPI Converter Command Decoder with Four-Pin GPIO

This block is the device side of the serial command path of a multichannel sampling converter. A host sends 16-bit command words over an SPI slave link: chip select low, data on the rising serial clock edge, most significant bit first. The block decodes each word and keeps two configuration registers. The first holds the conversion settings: output pin levels, a data-readback request, power-down and reference range. The second holds the pin setup: pin directions, alarm mode and two pin-function overrides. The block drives a 4-bit general-purpose port with a separate enable for each pin. During the next frame it shifts back a 16-bit response word. The word carries either a 12-bit conversion sample with its channel address, or the levels read on the four pins. The sample comes from a stimulus input rather than a real converter.

The SPI pins are sampled with the system clock, so each serial clock phase must last at least two system clocks. A receive state machine tracks each frame through its states `RX_IDLE`, `RX_SHIFT` and `RX_OVERRUN`:

- `RX_IDLE` goes to `RX_SHIFT` when chip select falls.
- `RX_SHIFT` goes to `RX_OVERRUN` on a rising serial clock edge that arrives after 16 bits have already been counted.
- `RX_SHIFT` goes back to `RX_IDLE` when chip select rises. The frame is committed only if exactly 16 bits were counted.
- `RX_OVERRUN` goes back to `RX_IDLE` when chip select rises. That frame is discarded.

Top module: `adc_cmd_dec`

## Requirements
- R1: After reset, all pins are inputs (`gpio_oe`=0), `gpio_out`=0, `range_sel`=0, `power_down`=0 and `alarm_mode`=0. The response shifted out in the first frame is 0x0000.
- R2: A frame is committed when chip select rises after exactly 16 rising serial clock edges. A frame with fewer or more edges changes no register and leaves the pending response unchanged.
- R3: Bits 15:12 of a committed word select its kind. 0x1 is a manual command and 0x4 is a pin setup command. Any other value changes no register.
- R4: A manual command stores bits 10:7 as the channel. When the readback flag is clear, the next frame's response is {channel[3:0], sample[11:0]}, where the sample is the value of `sample_in` when the response is built, just after the commit.
- R5: A manual command loads its bits 6:0 into the conversion settings only when its bit 11 is 1. The layout is: bits 3:0 pin levels, bit 4 readback flag, bit 5 power-down, bit 6 high range. When bit 11 is 0 these settings keep their values.
- R6: A pin setup command without bit 9 loads its bits 3:0 as pin directions, where 1 means output. `gpio_oe` equals the directions, and `gpio_out` is the stored level on output pins and 0 on input pins.
- R7: While the readback flag is set, each response built at a commit is {gpio_in[3:0], 12'h000}.
- R8: `range_sel` follows stored bit 6. When setup bit 7 is set, it follows `gpio_in[2]` instead.
- R9: `power_down` is stored bit 5 OR (setup bit 8 AND `gpio_in[3]`). A response built while `power_down` is 1 and the readback flag is clear has a sample field of 0.
- R10: A pin setup command with bit 9 set returns every register (both configuration registers and the channel) to its reset value.
- R11: A pin setup command without bit 9 stores bits 6:4 as `alarm_mode`.
- R12: `spi_miso` is 0 while chip select is high. In a frame, it presents the response most significant bit first, advancing one bit after each falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Command data from host |
| spi_miso | output | 1 | Response data to host |
| sample_in | input | 12 | Stimulus conversion value |
| gpio_in | input | 4 | Levels read on the four pins |
| gpio_out | output | 4 | Levels driven on the four pins |
| gpio_oe | output | 4 | Per-pin output enable |
| range_sel | output | 1 | Effective high reference range |
| power_down | output | 1 | Effective power-down |
| alarm_mode | output | 3 | Stored alarm mode selection |

## Verification
The bench builds the block with its default 16-bit frame and 12-bit sample field. At these values every field position of the command format is reachable. A 12-bit and a 20-bit frame take the counter on both sides of the commit count, and the overrun state is entered. Each field's effect is observed through the response shift-out and the pin outputs, including live pin overrides of range and power-down.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
    localparam logic [3:0] MODE_MANUAL = 4'h1;
    localparam logic [3:0] MODE_PINSET = 4'h4;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_OVERRUN
    } rx_state_e;

    // conversion settings, bit 6 down to bit 0
    typedef struct packed {
        logic       range_hi;
        logic       pwr_dn;
        logic       data_req;
        logic [3:0] level;
    } conv_cfg_t;

    // pin setup, bit 8 down to bit 0
    typedef struct packed {
        logic       pd_pin_en;
        logic       rng_pin_en;
        logic [2:0] alarm;
        logic [3:0] dir;
    } pin_cfg_t;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import adc_cmd_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               commit,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_start,
    output logic               shift_out,
    output logic               active
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic sclk_q, sclk_qq, cs_q, cs_qq, mosi_q;
    logic sclk_rise, sclk_fall, cs_fall, cs_rise;
    rx_state_e state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            cs_q    <= 1'b1;
            cs_qq   <= 1'b1;
            mosi_q  <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            cs_q    <= cs_n;
            cs_qq   <= cs_q;
            mosi_q  <= mosi;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_qq;
    assign sclk_fall = ~sclk_q & sclk_qq;
    assign cs_fall   = ~cs_q & cs_qq;
    assign cs_rise   = cs_q & ~cs_qq;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE:    if (cs_fall) state_nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (cs_rise)                        state_nxt = RX_IDLE;
                else if (sclk_rise && cnt == FULL)  state_nxt = RX_OVERRUN;
            end
            RX_OVERRUN: if (cs_rise) state_nxt = RX_IDLE;
            default:    state_nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shreg  <= '0;
            commit <= 1'b0;
        end else begin
            commit <= (state == RX_SHIFT) && cs_rise && (cnt == FULL);
            if (state == RX_IDLE && cs_fall) begin
                cnt <= '0;
            end else if (state == RX_SHIFT && sclk_rise && !cs_rise && cnt != FULL) begin
                shreg <= {shreg[FRAME_W-2:0], mosi_q};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        frame       = shreg;
        frame_start = (state == RX_IDLE) && cs_fall;
        shift_out   = (state != RX_IDLE) && sclk_fall;
        active      = (state != RX_IDLE);
    end
endmodule

// File: rtl/cmd_cfg_regs.sv
module cmd_cfg_regs
    import adc_cmd_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CHAN_W  = 4,
    parameter int N_PIN   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    input  logic [N_PIN-1:0]   gpio_in,
    output conv_cfg_t          conv_cfg,
    output logic [CHAN_W-1:0]  chan,
    output logic [N_PIN-1:0]   gpio_out,
    output logic [N_PIN-1:0]   gpio_oe,
    output logic               range_sel,
    output logic               power_down,
    output logic [2:0]         alarm_mode
);
    localparam int MODE_LSB = FRAME_W - 4;
    localparam int WR_BIT   = 11;
    localparam int CH_LSB   = 7;
    localparam int RST_BIT  = 9;

    pin_cfg_t pin_cfg;
    logic [3:0] mode;

    assign mode = frame[FRAME_W-1:MODE_LSB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cfg <= '0;
            pin_cfg  <= '0;
            chan     <= '0;
        end else if (commit) begin
            case (mode)
                MODE_MANUAL: begin
                    chan <= frame[CH_LSB+CHAN_W-1:CH_LSB];
                    if (frame[WR_BIT]) conv_cfg <= conv_cfg_t'(frame[6:0]);
                end
                MODE_PINSET: begin
                    if (frame[RST_BIT]) begin
                        conv_cfg <= '0;
                        pin_cfg  <= '0;
                        chan     <= '0;
                    end else begin
                        pin_cfg <= pin_cfg_t'(frame[8:0]);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        gpio_oe    = pin_cfg.dir;
        gpio_out   = conv_cfg.level & pin_cfg.dir;
        range_sel  = pin_cfg.rng_pin_en ? gpio_in[2] : conv_cfg.range_hi;
        power_down = conv_cfg.pwr_dn | (pin_cfg.pd_pin_en & gpio_in[3]);
        alarm_mode = pin_cfg.alarm;
    end
endmodule

// File: rtl/resp_shifter.sv
module resp_shifter #(
    parameter int FRAME_W = 16,
    parameter int CHAN_W  = 4,
    parameter int N_PIN   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_resp,
    input  logic                       frame_start,
    input  logic                       shift_out,
    input  logic                       active,
    input  logic                       data_req,
    input  logic                       power_down,
    input  logic [CHAN_W-1:0]          chan,
    input  logic [N_PIN-1:0]           gpio_in,
    input  logic [FRAME_W-CHAN_W-1:0]  sample,
    output logic [FRAME_W-1:0]         resp_word,
    output logic                       miso
);
    localparam int SMP_W = FRAME_W - CHAN_W;
    localparam int PAD_W = FRAME_W - N_PIN;

    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_word <= '0;
            sr        <= '0;
        end else begin
            if (load_resp) begin
                if (data_req)        resp_word <= {gpio_in, {PAD_W{1'b0}}};
                else if (power_down) resp_word <= {chan, {SMP_W{1'b0}}};
                else                 resp_word <= {chan, sample};
            end
            if (frame_start)    sr <= resp_word;
            else if (shift_out) sr <= {sr[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso = active & sr[FRAME_W-1];
endmodule

// File: rtl/adc_cmd_dec.sv
module adc_cmd_dec
    import adc_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic [11:0] sample_in,
    input  logic [3:0]  gpio_in,
    output logic [3:0]  gpio_out,
    output logic [3:0]  gpio_oe,
    output logic        range_sel,
    output logic        power_down,
    output logic [2:0]  alarm_mode
);
    localparam int FRAME_W = 16;
    localparam int CHAN_W  = 4;
    localparam int N_PIN   = 4;

    logic               commit, load_resp, frame_start, shift_out, active;
    logic [FRAME_W-1:0] frame_w, resp_word;
    conv_cfg_t          conv_cfg;
    logic [CHAN_W-1:0]  chan;

    spi_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .commit(commit), .frame(frame_w), .frame_start(frame_start),
        .shift_out(shift_out), .active(active)
    );

    cmd_cfg_regs #(.FRAME_W(FRAME_W), .CHAN_W(CHAN_W), .N_PIN(N_PIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .frame(frame_w), .gpio_in(gpio_in),
        .conv_cfg(conv_cfg), .chan(chan), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .range_sel(range_sel), .power_down(power_down), .alarm_mode(alarm_mode)
    );

    // response is built one cycle after the registers take the commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) load_resp <= 1'b0;
        else        load_resp <= commit;
    end

    resp_shifter #(.FRAME_W(FRAME_W), .CHAN_W(CHAN_W), .N_PIN(N_PIN)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_resp(load_resp), .frame_start(frame_start),
        .shift_out(shift_out), .active(active), .data_req(conv_cfg.data_req),
        .power_down(power_down), .chan(chan), .gpio_in(gpio_in), .sample(sample_in),
        .resp_word(resp_word), .miso(spi_miso)
    );
endmodule

// File: rtl/adc_cmd_dec_checks.sv
module adc_cmd_dec_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        commit,
    input logic [15:0] frame_w,
    input logic        load_resp,
    input logic [15:0] resp_word,
    input logic [6:0]  conv_bits,
    input logic [3:0]  chan,
    input logic [3:0]  gpio_in,
    input logic [3:0]  gpio_oe,
    input logic [3:0]  gpio_out,
    input logic        range_sel,
    input logic        power_down,
    input logic [2:0]  alarm_mode
);
    assert_single_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(conv_bits) && $stable(chan) && $stable(gpio_oe) && $stable(alarm_mode));

    assert_bad_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_w[15:12] != 4'h1 && frame_w[15:12] != 4'h4)
        |=> $stable(conv_bits) && $stable(chan) && $stable(gpio_oe) && $stable(alarm_mode));

    assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_w[15:12] == 4'h1 && !frame_w[11]) |=> $stable(conv_bits));

    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_resp && conv_bits[4]) |=> resp_word == {$past(gpio_in), 12'h000});

    assert_pd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_resp && power_down && !conv_bits[4]) |=> resp_word[11:0] == 12'h000);

    assert_reg_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_w[15:12] == 4'h4 && frame_w[9])
        |=> gpio_oe == 4'h0 && gpio_out == 4'h0 && !range_sel && !power_down
            && alarm_mode == 3'h0 && chan == 4'h0);
endmodule

bind adc_cmd_dec adc_cmd_dec_checks u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .frame_w(frame_w),
    .load_resp(load_resp), .resp_word(resp_word), .conv_bits(conv_cfg),
    .chan(chan), .gpio_in(gpio_in), .gpio_oe(gpio_oe), .gpio_out(gpio_out),
    .range_sel(range_sel), .power_down(power_down), .alarm_mode(alarm_mode)
);

// File: tb/test_adc_cmd_dec.sv
module test_adc_cmd_dec;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [11:0] sample_in = '0;
    logic [3:0]  gpio_in = '0;
    logic [3:0]  gpio_out, gpio_oe;
    logic        range_sel, power_down;
    logic [2:0]  alarm_mode;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // bench model state
    logic [3:0] m_level = 0, m_dir = 0, m_chan = 0;
    logic       m_req = 0, m_pd = 0, m_rng = 0, m_rie = 0, m_pie = 0;
    logic [2:0] m_alarm = 0;
    logic [15:0] m_resp = 16'h0000;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] rx_word;
    event        frame_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cmd_dec i_adc_cmd_dec (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sample_in(sample_in),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .range_sel(range_sel), .power_down(power_down), .alarm_mode(alarm_mode)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_commit(input logic [15:0] cmd);
        logic eff_pd;
        if (cmd[15:12] == 4'h1) begin
            m_chan = cmd[10:7];
            if (cmd[11]) {m_rng, m_pd, m_req, m_level} = cmd[6:0];
        end else if (cmd[15:12] == 4'h4) begin
            if (cmd[9]) begin
                {m_rng, m_pd, m_req, m_level} = '0;
                {m_pie, m_rie, m_alarm, m_dir} = '0;
                m_chan = '0;
            end else begin
                {m_pie, m_rie, m_alarm, m_dir} = cmd[8:0];
            end
        end
        eff_pd = m_pd | (m_pie & gpio_in[3]);
        if (m_req)       m_resp = {gpio_in, 12'h000};
        else if (eff_pd) m_resp = {m_chan, 12'h000};
        else             m_resp = {m_chan, sample_in};
    endtask

    task automatic chk_ports(input string req);
        logic [15:0] act, exp;
        act = {3'b0, gpio_oe, gpio_out, range_sel, power_down, alarm_mode};
        exp = {3'b0, m_dir, m_level & m_dir,
               (m_rie ? gpio_in[2] : m_rng), (m_pd | (m_pie & gpio_in[3])), m_alarm};
        check(act == exp, req, act, exp);
    endtask

    // driver: pushes the expected response, then shifts the frame
    task automatic send(input logic [15:0] cmd, input int nbits, input logic [11:0] smp, input string tag);
        logic [15:0] got;
        sample_in = smp;
        if (nbits == 16) begin
            exp_q.push_back(m_resp);
            tag_q.push_back(tag);
        end
        got = '0;
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? cmd[15-i] : 1'b1;
            if (i < 16) got = {got[14:0], spi_miso};
            repeat (2) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        if (nbits == 16) begin
            m_commit(cmd);
            rx_word = got;
            -> frame_done;
        end
    endtask

    // monitor: compares each received response against the queue
    initial begin
        forever begin
            logic [15:0] e;
            string t;
            @(frame_done);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rx_word == e, t, rx_word, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_ports("R1 reset outputs");
        check(spi_miso == 1'b0, "R12 miso idle", {15'b0, spi_miso}, 16'h0);

        // R1 first response 0; manual write: chan 5, range hi, levels 1010
        send(16'h1000 | 16'h0800 | (16'd5 << 7) | 16'h0040 | 16'h000A, 16, 12'hABC, "R1 first response");
        chk_ports("R6 inputs keep gpio_out low");
        chk_ports("R8 range from stored bit");
        // pin setup: dir 0011, alarm 101
        send(16'h4000 | (16'd5 << 4) | 16'h0003, 16, 12'h123, "R4 chan5 sample");
        chk_ports("R6 R11 directions and alarm");
        // manual without write flag, all config bits set
        send(16'h1000 | (16'd9 << 7) | 16'h007F, 16, 12'h456, "R12 msb first");
        chk_ports("R5 no write keeps settings");
        // short and long frames with a write
        send(16'h1800 | (16'd2 << 7) | 16'h000F, 12, 12'h777, "R2 short");
        chk_ports("R2 short frame discarded");
        send(16'h1800 | (16'd3 << 7) | 16'h000F, 20, 12'h777, "R2 long");
        chk_ports("R2 long frame discarded");
        // unknown mode
        send(16'h2800 | (16'd7 << 7) | 16'h003F, 16, 12'h5A5, "R2 R4 chan9 after discards");
        chk_ports("R3 unknown mode ignored");
        // readback request
        gpio_in = 4'b0110;
        send(16'h1800 | (16'd1 << 7) | 16'h0050 | 16'h000A, 16, 12'h321, "R3 chan unchanged");
        send(16'h1000 | (16'd4 << 7), 16, 12'hFED, "R7 pin levels returned");
        gpio_in = 4'b1001;
        send(16'h1800 | (16'd6 << 7) | 16'h0040, 16, 12'h0F0, "R7 readback persists");
        // power-down
        send(16'h1800 | (16'd8 << 7) | 16'h0020, 16, 12'h9AB, "R4 chan6 after readback clear");
        chk_ports("R9 stored power-down");
        send(16'h1800 | (16'd8 << 7), 16, 12'hCDE, "R9 sample zero in power-down");
        // pin overrides
        gpio_in = 4'b0000;
        send(16'h4000 | 16'h0180 | 16'h0001, 16, 12'h111, "R4 chan8 sample");
        chk_ports("R8 R9 overrides with pins low");
        gpio_in = 4'b1100;
        repeat (3) @(negedge clk);
        chk_ports("R8 range follows pin2");
        chk_ports("R9 power-down follows pin3");
        send(16'h1000 | (16'd10 << 7), 16, 12'h222, "R9 pd input blanks sample");
        // register reset
        send(16'h4000 | 16'h0200 | 16'h01FF, 16, 12'h333, "R9 pd still forced");
        chk_ports("R10 all registers reset");
        send(16'h1000, 16, 12'h444, "R10 response chan0");
        check(spi_miso == 1'b0, "R12 miso idle after frames", {15'b0, spi_miso}, 16'h0);

        repeat (10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule